// File: doc/BRIEF.md
# Predicate Register File with Guarded Compare Unit

This block holds the single-bit predicates that steer predicated execution. It also holds the compare unit that produces them. A compare tests two integer operands for equality or for inequality. In one cycle it writes two predicate registers: a "true" target that receives the result and a "false" target that receives the inverse. Each compare carries a guard, which is itself a predicate. In the normal form, a false guard leaves both targets as they were. In the unconditional form, a false guard forces both targets to zero. This lets a chain of compares evaluate nested `if / else if / else` conditions without branches.

Downstream operations present the index of their guard predicate on a read port. The block returns a commit enable for each one. An operation whose guard is false is nullified. Predicate 0 always reads as one, so it serves as the guard for operations that are not predicated.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset, predicate 0 reads as 1 and predicates 1 to 15 read as 0.
- R2: An accepted compare with relation code 0 (equal) writes (A == B) to the true target and the inverse to the false target. The new values are visible on the read ports from the cycle after the compare.
- R3: An accepted compare with relation code 1 (not equal) writes (A != B) to the true target and the inverse to the false target.
- R4: In the normal form (cmpUnc = 0), a compare whose guard predicate is 0 leaves both targets unchanged.
- R5: In the unconditional form (cmpUnc = 1), a compare whose guard predicate is 0 writes 0 to both targets.
- R6: In the unconditional form, a compare whose guard predicate is 1 writes the same values as the normal form.
- R7: Predicate 0 reads as 1 at all times, and a compare that targets it leaves it unchanged.
- R8: If both targets of one compare name the same predicate, the false-target value is the one stored.
- R9: Each opCommit bit equals its opValid bit AND the predicate named by its guard index. An operation with opValid = 0 never commits.
- R10: A compare may use, as its guard, a predicate written by the compare in the cycle just before it. The guard value it sees is the updated one.
- R11: When cmpValid is 0, no predicate changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | A compare is presented this cycle |
| cmpRel | input | 1 | Relation code: 0 equal, 1 not equal |
| cmpUnc | input | 1 | 1 selects the unconditional form |
| cmpGuard | input | 4 | Index of the compare's guard predicate |
| cmpDstT | input | 4 | Index of the true target |
| cmpDstF | input | 4 | Index of the false target |
| cmpOpA | input | 32 | First integer operand |
| cmpOpB | input | 32 | Second integer operand |
| opValid | input | 2 | One bit per operation slot: slot holds an operation |
| opGuard | input | 8 | Guard predicate index per slot, slot n in bits [4n+3:4n] |
| opCommit | output | 2 | Commit enable per slot |

## Verification
Two cases are the hardest to reach from the ports. The first is a guard that is false because an earlier compare cleared it. The second is a target that already holds a value that differs from what a guarded-off compare would have written. Only with both in place can R4 and R5 be told apart. The stimulus table therefore replays two passes of a nested if / else-if / else chain with different operand values. Later entries are guarded by predicates that earlier entries set or cleared. Directed cases then issue compares back to back, to cover guard forwarding. They also aim both targets at one register and aim writes at predicate 0.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic {
    REL_EQ = 1'b0,
    REL_NE = 1'b1
  } relKind_e;

  // Write strobes from control to datapath for one compare
  typedef struct packed {
    logic wrT;
    logic wrF;
    logic valT;
    logic valF;
  } predWrStrb_t;

endpackage

// File: rtl/pred_cmp_ctrl.sv
module pred_cmp_ctrl
  import pred_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpValid,
  input  logic              cmpRel,
  input  logic              cmpUnc,
  input  logic              guardBit,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  output predWrStrb_t       strb
);

  localparam int unsigned NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W  = NCHUNK * CHUNK_W;

  logic [PAD_W-1:0]  diffPad;
  logic [NCHUNK-1:0] chunkEq;
  logic              opsEqual;
  logic              relResult;

  // Zero-extend the bitwise difference so every chunk is full width
  always_comb begin
    diffPad = '0;
    diffPad[DATA_W-1:0] = cmpOpA ^ cmpOpB;
  end

  // Equality reduced per chunk, then across chunks
  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunkEq[c] = ~|diffPad[c*CHUNK_W +: CHUNK_W];
  end

  assign opsEqual  = &chunkEq;
  assign relResult = (relKind_e'(cmpRel) == REL_NE) ? ~opsEqual : opsEqual;

  always_comb begin
    strb = '0;
    if (cmpUnc) begin
      // Unconditional form: always writes, results masked by guard
      strb.wrT  = cmpValid;
      strb.wrF  = cmpValid;
      strb.valT = guardBit & relResult;
      strb.valF = guardBit & ~relResult;
    end else begin
      // Normal form: writes only when the guard holds
      strb.wrT  = cmpValid & guardBit;
      strb.wrF  = cmpValid & guardBit;
      strb.valT = relResult;
      strb.valF = ~relResult;
    end
  end

  // R11: no compare presented, no write strobe
  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpValid |-> (!strb.wrT && !strb.wrF));

  // R5: unconditional form with false guard writes zeros to both
  p_unc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && cmpUnc && !guardBit) |-> (strb.wrT && strb.wrF && !strb.valT && !strb.valF));

  // R2: written values are complementary
  p_values_cpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrT && guardBit) |-> (strb.valT != strb.valF));

endmodule

// File: rtl/pred_file_dp.sv
module pred_file_dp
  import pred_pkg::*;
#(
  parameter int unsigned NUM_PREDS = 16,
  parameter int unsigned NUM_OPS   = 2,
  localparam int unsigned PIDX_W   = $clog2(NUM_PREDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  predWrStrb_t                 strb,
  input  logic [PIDX_W-1:0]           dstT,
  input  logic [PIDX_W-1:0]           dstF,
  input  logic [PIDX_W-1:0]           cmpGuard,
  input  logic [NUM_OPS-1:0]          opValid,
  input  logic [NUM_OPS*PIDX_W-1:0]   opGuard,
  output logic                        guardBit,
  output logic [NUM_OPS-1:0]          opCommit,
  output logic [NUM_PREDS-1:0]        predVec
);

  for (genvar p = 0; p < NUM_PREDS; p++) begin : g_pred
    if (p == 0) begin : g_true
      // Entry 0 is a constant one; writes aimed at it are dropped
      assign predVec[p] = 1'b1;
    end else begin : g_reg
      logic predQ;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          predQ <= 1'b0;
        end else if (strb.wrF && (dstF == PIDX_W'(p))) begin
          // False-target write takes precedence on a shared index
          predQ <= strb.valF;
        end else if (strb.wrT && (dstT == PIDX_W'(p))) begin
          predQ <= strb.valT;
        end
      end
      assign predVec[p] = predQ;
    end
  end

  assign guardBit = predVec[cmpGuard];

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    logic [PIDX_W-1:0] opIdx;
    assign opIdx       = opGuard[o*PIDX_W +: PIDX_W];
    assign opCommit[o] = opValid[o] & predVec[opIdx];

    // R9: an empty slot never commits
    p_empty_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !opValid[o] |-> !opCommit[o]);
  end

  // R11: without strobes the array holds
  p_hold_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrT && !strb.wrF) |=> $stable(predVec));

  // R7: entry 0 always true
  p_entry0_true_r7: assert property (@(posedge clk) disable iff (!rst_n)
    predVec[0]);

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_PREDS = 16,
  parameter int unsigned NUM_OPS   = 2,
  localparam int unsigned PIDX_W   = $clog2(NUM_PREDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmpValid,
  input  logic                      cmpRel,
  input  logic                      cmpUnc,
  input  logic [PIDX_W-1:0]         cmpGuard,
  input  logic [PIDX_W-1:0]         cmpDstT,
  input  logic [PIDX_W-1:0]         cmpDstF,
  input  logic [DATA_W-1:0]         cmpOpA,
  input  logic [DATA_W-1:0]         cmpOpB,
  input  logic [NUM_OPS-1:0]        opValid,
  input  logic [NUM_OPS*PIDX_W-1:0] opGuard,
  output logic [NUM_OPS-1:0]        opCommit
);

  predWrStrb_t          strb;
  logic                 guardBit;
  logic [NUM_PREDS-1:0] predVec;

  pred_cmp_ctrl #(
    .DATA_W (DATA_W),
    .CHUNK_W(8)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmpValid(cmpValid),
    .cmpRel  (cmpRel),
    .cmpUnc  (cmpUnc),
    .guardBit(guardBit),
    .cmpOpA  (cmpOpA),
    .cmpOpB  (cmpOpB),
    .strb    (strb)
  );

  pred_file_dp #(
    .NUM_PREDS(NUM_PREDS),
    .NUM_OPS  (NUM_OPS)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .dstT    (cmpDstT),
    .dstF    (cmpDstF),
    .cmpGuard(cmpGuard),
    .opValid (opValid),
    .opGuard (opGuard),
    .guardBit(guardBit),
    .opCommit(opCommit),
    .predVec (predVec)
  );

  // R4: normal form with false guard leaves the whole array untouched
  p_guard_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && !cmpUnc && !guardBit) |=> $stable(predVec));

  // R5: unconditional form with false guard clears a non-zero true target
  p_unc_clears_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && cmpUnc && !guardBit && (cmpDstT != '0)) |=> !predVec[$past(cmpDstT)]);

  // R2: distinct non-zero targets end up complementary after a live compare
  p_targets_cpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && guardBit && (cmpDstT != cmpDstF) && (cmpDstT != '0) && (cmpDstF != '0))
    |=> (predVec[$past(cmpDstT)] != predVec[$past(cmpDstF)]));

  // R8: shared target stores the false-target value
  p_shared_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && guardBit && (cmpDstT == cmpDstF) && (cmpDstT != '0))
    |=> (predVec[$past(cmpDstT)] == ($past(cmpRel) ? ($past(cmpOpA) == $past(cmpOpB))
                                                   : ($past(cmpOpA) != $past(cmpOpB)))));

endmodule

// File: tb/pred_cmp_unit_tb_top.sv
module pred_cmp_unit_tb_top;

  typedef struct packed {
    logic        rel;
    logic        unc;
    logic [3:0]  guard;
    logic [3:0]  dstT;
    logic [3:0]  dstF;
    logic [31:0] opA;
    logic [31:0] opB;
    logic        expT;
    logic        expF;
    logic [7:0]  req;
  } vec_t;

  // Two passes of a nested if / else-if / else chain, then corner entries
  localparam int NVEC = 15;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b0, 1'b0, 4'd0,  4'd1,  4'd2,  32'd0, 32'd5, 1'b0, 1'b1, 8'd2},  // R2 A false
    '{1'b0, 1'b0, 4'd2,  4'd1,  4'd3,  32'd0, 32'd0, 1'b1, 1'b0, 8'd2},  // else branch test
    '{1'b1, 1'b1, 4'd1,  4'd4,  4'd5,  32'd0, 32'd7, 1'b1, 1'b0, 8'd6},  // R6 unc live guard
    '{1'b0, 1'b0, 4'd0,  4'd1,  4'd2,  32'd0, 32'd0, 1'b1, 1'b0, 8'd2},  // second pass
    '{1'b0, 1'b0, 4'd2,  4'd1,  4'd3,  32'd0, 32'd9, 1'b1, 1'b0, 8'd4},  // R4 guard off
    '{1'b1, 1'b1, 4'd1,  4'd4,  4'd5,  32'd0, 32'd0, 1'b0, 1'b1, 8'd6},  // R6
    '{1'b0, 1'b1, 4'd3,  4'd4,  4'd5,  32'd3, 32'd3, 1'b0, 1'b0, 8'd5},  // R5 clears both
    '{1'b1, 1'b0, 4'd0,  4'd6,  4'd7,  32'd1, 32'd2, 1'b1, 1'b0, 8'd3},  // R3
    '{1'b1, 1'b0, 4'd6,  4'd8,  4'd9,  32'd4, 32'd4, 1'b0, 1'b1, 8'd3},  // R3 equal ops
    '{1'b0, 1'b1, 4'd9,  4'd10, 4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd6},
    '{1'b0, 1'b0, 4'd0,  4'd12, 4'd12, 32'd1, 32'd1, 1'b0, 1'b0, 8'd8},  // R8
    '{1'b0, 1'b0, 4'd0,  4'd12, 4'd12, 32'd1, 32'd2, 1'b1, 1'b1, 8'd8},  // R8
    '{1'b0, 1'b0, 4'd0,  4'd0,  4'd13, 32'd1, 32'd2, 1'b1, 1'b1, 8'd7},  // R7 T at p0
    '{1'b0, 1'b0, 4'd0,  4'd14, 4'd0,  32'd5, 32'd5, 1'b1, 1'b1, 8'd7},  // R7 F at p0
    '{1'b0, 1'b0, 4'd15, 4'd1,  4'd2,  32'd0, 32'd9, 1'b1, 1'b0, 8'd4}   // R4 never-set guard
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpValid = 1'b0;
  logic        cmpRel = 1'b0;
  logic        cmpUnc = 1'b0;
  logic [3:0]  cmpGuard = '0;
  logic [3:0]  cmpDstT = '0;
  logic [3:0]  cmpDstF = '0;
  logic [31:0] cmpOpA = '0;
  logic [31:0] cmpOpB = '0;
  logic [1:0]  opValid = '0;
  logic [7:0]  opGuard = '0;
  logic [1:0]  opCommit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pred_cmp_unit dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmpValid(cmpValid),
    .cmpRel  (cmpRel),
    .cmpUnc  (cmpUnc),
    .cmpGuard(cmpGuard),
    .cmpDstT (cmpDstT),
    .cmpDstF (cmpDstF),
    .cmpOpA  (cmpOpA),
    .cmpOpB  (cmpOpB),
    .opValid (opValid),
    .opGuard (opGuard),
    .opCommit(opCommit)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Read two predicates through the operation slots (call after a negedge)
  task automatic readPair(input logic [3:0] a, input logic [3:0] b, output logic va, output logic vb);
    opValid = 2'b11;
    opGuard = {b, a};
    #1;
    va = opCommit[0];
    vb = opCommit[1];
  endtask

  task automatic issueCmp(input logic rel, input logic unc, input logic [3:0] g,
                          input logic [3:0] t, input logic [3:0] f,
                          input logic [31:0] a, input logic [31:0] b);
    cmpValid = 1'b1; cmpRel = rel; cmpUnc = unc; cmpGuard = g;
    cmpDstT = t; cmpDstF = f; cmpOpA = a; cmpOpB = b;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic va, vb;
    logic [15:0] snap;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state of all entries
    for (int p = 0; p < 16; p += 2) begin
      @(negedge clk);
      readPair(4'(p), 4'(p + 1), va, vb);
      check("R1", va, (p == 0), $sformatf("p%0d after reset", p));
      check("R1", vb, 1'b0, $sformatf("p%0d after reset", p + 1));
    end

    // Table walk: one compare, then read both targets the next cycle
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opValid = '0;
      issueCmp(VECS[i].rel, VECS[i].unc, VECS[i].guard, VECS[i].dstT, VECS[i].dstF,
               VECS[i].opA, VECS[i].opB);
      @(negedge clk);
      cmpValid = 1'b0;
      readPair(VECS[i].dstT, VECS[i].dstF, va, vb);
      check($sformatf("R%0d", VECS[i].req), va, VECS[i].expT, $sformatf("vec %0d true target", i));
      check($sformatf("R%0d", VECS[i].req), vb, VECS[i].expF, $sformatf("vec %0d false target", i));
    end

    // R9: empty slots never commit, even on predicate 0
    @(negedge clk);
    opValid = 2'b00; opGuard = 8'h00; #1;
    check("R9", opCommit[0], 1'b0, "slot0 empty on p0");
    check("R9", opCommit[1], 1'b0, "slot1 empty on p0");
    opValid = 2'b10; opGuard = {4'd12, 4'd0}; #1;
    check("R9", opCommit[0], 1'b0, "slot0 empty");
    check("R9", opCommit[1], 1'b1, "slot1 live on p12");

    // R11: compare fields present but cmpValid low
    for (int p = 0; p < 16; p += 2) begin
      readPair(4'(p), 4'(p + 1), va, vb);
      snap[p] = va; snap[p+1] = vb;
    end
    @(negedge clk);
    issueCmp(1'b0, 1'b1, 4'd3, 4'd1, 4'd12, 32'd7, 32'd8);
    cmpValid = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 16; p += 2) begin
      readPair(4'(p), 4'(p + 1), va, vb);
      check("R11", va, snap[p], $sformatf("p%0d idle", p));
      check("R11", vb, snap[p+1], $sformatf("p%0d idle", p + 1));
    end

    // R10: back-to-back, second compare guarded by first's true target
    @(negedge clk);
    issueCmp(1'b0, 1'b0, 4'd0, 4'd2, 4'd3, 32'd4, 32'd4);   // p2=1, p3=0
    @(negedge clk);
    issueCmp(1'b1, 1'b0, 4'd2, 4'd6, 4'd7, 32'd5, 32'd5);   // guard p2 now 1: p6=0, p7=1
    @(negedge clk);
    issueCmp(1'b0, 1'b0, 4'd3, 4'd6, 4'd7, 32'd1, 32'd1);   // guard p3 now 0: no change
    @(negedge clk);
    cmpValid = 1'b0;
    readPair(4'd6, 4'd7, va, vb);
    check("R10", va, 1'b0, "p6 via forwarded guard");
    check("R10", vb, 1'b1, "p7 via forwarded guard");

    // R1: second reset clears written entries again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    readPair(4'd7, 4'd0, va, vb);
    check("R1", va, 1'b0, "p7 after re-reset");
    check("R1", vb, 1'b1, "p0 after re-reset");

    @(negedge clk);
    finish();
  end

endmodule